// File: doc/BRIEF.md
# Doubleword Rotate-and-Mask Unit

This block computes the results of the doubleword rotate instruction group in a RISC integer pipeline. It takes the 32-bit instruction word and the already-read operands. A three-bit field of the instruction selects one of five sub-operations: four immediate-amount forms and one register-amount form. The register-amount form serves two instructions. A separate instruction bit decides at execute time whether that form clears from the left or from the right.

The unit is purely combinational. Every operation rotates the source operand left and then applies a contiguous mask. The mask may wrap around. The insert form fills the bits outside the mask from the destination's old value, which arrives on the auxiliary operand. Illegal field values produce a flag and a zero result. The record bit is forwarded so that the pipeline can update the condition register later.

Instruction bits are numbered with 0 as the least significant bit. Positions inside the 64-bit data are numbered with 0 as the most significant bit (vector bit 63). MASK(b,e) is all ones from position b to position e. When b > e it wraps: ones from b to 63 and from 0 to e.

Top module: `rot_mask_unit`

## Requirements
- R1: The sub-operation is selected by instruction bits [4:2]. Instruction bits [31:5] have no effect on any output.
- R2: Field 000 yields ROTL(src, sh) AND MASK(mb, 63).
- R3: Field 001 yields ROTL(src, sh) AND MASK(0, mb). Here the mask-boundary input acts as the mask end.
- R4: Field 010 yields ROTL(src, sh) AND MASK(mb, 63-sh). The mask wraps when mb > 63-sh.
- R5: Field 011 yields (ROTL(src, sh) AND M) OR (aux AND NOT M), with M = MASK(mb, 63-sh). Bits outside M keep the aux value.
- R6: Field 100 rotates by aux vector bits [5:0]. Instruction bit 1 = 0 applies MASK(mb, 63), and instruction bit 1 = 1 applies MASK(0, mb).
- R7: Fields 101, 110 and 111 drive illegal_o = 1, valid_o = 0, result_o = 0 and rc_o = 0.
- R8: valid_o is 1 exactly when the field is legal. For legal fields, rc_o equals instruction bit 0.
- R9: The register-amount form ignores sh_i and aux vector bits [63:6]. The immediate clear forms (000, 001, 010) ignore aux_i entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Operand to rotate |
| aux_i | input | 64 | Rotate amount (register form) or old destination value (insert form) |
| sh_i | input | 6 | Immediate rotate amount |
| mb_i | input | 6 | Mask-boundary constant (begin or end, depending on the form) |
| result_o | output | 64 | Computed result |
| valid_o | output | 1 | Legal operation, result is meaningful |
| illegal_o | output | 1 | Illegal sub-operation field |
| rc_o | output | 1 | Record flag for condition update |

## Verification
On every evaluation, the assertions check three properties:
- Inside the mask, the result matches the rotator output.
- Outside the mask, the result is zero for the clear forms and follows aux for the insert form.
- Illegal fields give a quiet, flagged zero.

They cannot tell whether the mask bounds themselves are correct for each form, including the wrap case, the left/right choice made by instruction bit 1, and the choice of rotate-amount source. Only the bench's bit-level reference comparisons show those, together with the checks that ignored inputs have no effect.

// File: rtl/rot_mask_pkg.sv
package rot_mask_pkg;
  typedef enum logic [2:0] {
    RM_CLR_LEFT_IMM,
    RM_CLR_RIGHT_IMM,
    RM_CLR_IMM,
    RM_INSERT_IMM,
    RM_CLR_LEFT_REG,
    RM_CLR_RIGHT_REG,
    RM_BAD
  } rm_op_e;
endpackage

// File: rtl/rm_subop_dec.sv
module rm_subop_dec
  import rot_mask_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       dir_i,
  output rm_op_e     op_o,
  output logic       legal_o
);
  always_comb begin
    case (sel_i)
      3'b000:  op_o = RM_CLR_LEFT_IMM;
      3'b001:  op_o = RM_CLR_RIGHT_IMM;
      3'b010:  op_o = RM_CLR_IMM;
      3'b011:  op_o = RM_INSERT_IMM;
      3'b100:  op_o = dir_i ? RM_CLR_RIGHT_REG : RM_CLR_LEFT_REG;
      default: op_o = RM_BAD;
    endcase
  end
  assign legal_o = (sel_i[2] == 1'b0) || (sel_i[1:0] == 2'b00);
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   data_o
);
  logic [2*W-1:0] dbl;
  assign dbl    = {data_i, data_i} << amt_i;
  assign data_o = dbl[2*W-1:W];
endmodule

// File: rtl/rm_mask_gen.sv
// Positions are MSB-first: position p is vector bit W-1-p.
module rm_mask_gen #(
  parameter int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [SHW-1:0] begin_i,
  input  logic [SHW-1:0] end_i,
  output logic [W-1:0]   mask_o
);
  localparam logic [SHW-1:0] TOP = SHW'(W - 1);
  logic [W-1:0]   from_b, to_e;
  logic [SHW-1:0] e_shift;
  assign e_shift = TOP - end_i;
  assign from_b  = {W{1'b1}} >> begin_i;
  assign to_e    = {W{1'b1}} << e_shift;
  // Ordinary range is the overlap; reversed bounds wrap around.
  assign mask_o  = (begin_i <= end_i) ? (from_b & to_e) : (from_b | to_e);
endmodule

// File: rtl/rot_mask_unit.sv
module rot_mask_unit
  import rot_mask_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned ILEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [ILEN-1:0] insn_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] aux_i,
  input  logic [SHW-1:0]  sh_i,
  input  logic [SHW-1:0]  mb_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic            illegal_o,
  output logic            rc_o
);
  localparam logic [SHW-1:0] TOP = SHW'(XLEN - 1);

  rm_op_e          op;
  logic            legal;
  logic [SHW-1:0]  amt, m_beg, m_end;
  logic [XLEN-1:0] rot, mask;
  logic            unused_insn;

  assign unused_insn = ^insn_i[ILEN-1:5];

  rm_subop_dec u_dec (
    .sel_i   (insn_i[4:2]),
    .dir_i   (insn_i[1]),
    .op_o    (op),
    .legal_o (legal)
  );

  assign amt = (op == RM_CLR_LEFT_REG || op == RM_CLR_RIGHT_REG) ? aux_i[SHW-1:0] : sh_i;

  always_comb begin
    m_beg = mb_i;
    m_end = TOP;
    case (op)
      RM_CLR_RIGHT_IMM, RM_CLR_RIGHT_REG: begin
        m_beg = '0;
        m_end = mb_i;
      end
      RM_CLR_IMM, RM_INSERT_IMM: m_end = TOP - sh_i;
      default: ;
    endcase
  end

  rm_rotator #(.W(XLEN)) u_rot (
    .data_i (src_i),
    .amt_i  (amt),
    .data_o (rot)
  );

  rm_mask_gen #(.W(XLEN)) u_mask (
    .begin_i (m_beg),
    .end_i   (m_end),
    .mask_o  (mask)
  );

  always_comb begin
    if (!legal)                  result_o = '0;
    else if (op == RM_INSERT_IMM) result_o = (rot & mask) | (aux_i & ~mask);
    else                         result_o = rot & mask;
  end

  assign valid_o   = legal;
  assign illegal_o = ~legal;
  assign rc_o      = legal & insn_i[0];

  always_comb begin
    if (illegal_o)
      assert_illegal_quiet_R7: assert (result_o == '0 && !valid_o && !rc_o);
    assert_flag_excl_R8: assert (valid_o != illegal_o);
    if (valid_o) begin
      assert_in_mask_rot_R2: assert (((result_o ^ rot) & mask) == '0);
      assert_rc_pass_R8: assert (rc_o == insn_i[0]);
    end
    if (valid_o && op != RM_INSERT_IMM)
      assert_clear_outside_R4: assert ((result_o & ~mask) == '0);
    if (valid_o && op == RM_INSERT_IMM)
      assert_insert_keep_R5: assert (((result_o ^ aux_i) & ~mask) == '0);
  end
endmodule

// File: tb/rot_mask_unit_tb.sv
module rot_mask_unit_tb_top;
  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] src;
    logic [63:0] aux;
    logic [5:0]  sh;
    logic [5:0]  mb;
  } vec_t;

  // insn bits [4:2] = field, bit 1 = direction, bit 0 = record
  localparam int NV = 12;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 6'd8,  6'd16}, // R2
    '{32'h0000_0001, 64'h8000_0000_0000_0001, 64'h0,                   6'd1,  6'd0 }, // R2
    '{32'h0000_0004, 64'h0123_4567_89AB_CDEF, 64'h1234,                6'd4,  6'd31}, // R3
    '{32'hF800_0005, 64'hDEAD_BEEF_CAFE_F00D, 64'h0,                   6'd63, 6'd63}, // R3, R1
    '{32'h0000_0008, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   6'd10, 6'd5 }, // R4
    '{32'h0000_0008, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0,                   6'd20, 6'd50}, // R4 wrap
    '{32'h0000_000C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_AAAA_5555_AAAA, 6'd16, 6'd8 }, // R5
    '{32'h0000_000D, 64'h1111_2222_3333_4444, 64'hAAAA_AAAA_AAAA_AAAA, 6'd40, 6'd60}, // R5 wrap
    '{32'h0000_0010, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF0C, 6'd0,  6'd4 }, // R6 left
    '{32'h0000_0012, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0023, 6'd7,  6'd40}, // R6 right
    '{32'h0000_0013, 64'h8765_4321_0FED_CBA9, 64'h0,                   6'd33, 6'd0 }, // R6 right
    '{32'h0000_0014, 64'h0123_4567_89AB_CDEF, 64'h1,                   6'd1,  6'd1 }  // R7
  };

  logic        clk = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_i = '0, aux_i = '0;
  logic [5:0]  sh_i = '0, mb_i = '0;
  logic [63:0] result_o;
  logic        valid_o, illegal_o, rc_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rot_mask_unit dut_i (
    .insn_i, .src_i, .aux_i, .sh_i, .mb_i,
    .result_o, .valid_o, .illegal_o, .rc_o
  );

  function automatic logic ref_legal(input logic [31:0] insn);
    return insn[4:2] <= 3'd4;
  endfunction

  function automatic logic [63:0] ref_res(input vec_t v);
    int sel, n, b, e;
    logic [63:0] r;
    logic inm;
    sel = int'(v.insn[4:2]);
    n = (sel == 4) ? int'(v.aux[5:0]) : int'(v.sh);
    b = int'(v.mb); e = 63;
    case (sel)
      0: ;
      1: begin b = 0; e = int'(v.mb); end
      2, 3: e = 63 - int'(v.sh);
      4: if (v.insn[1]) begin b = 0; e = int'(v.mb); end
      default: return 64'h0;
    endcase
    for (int p = 0; p < 64; p++) begin
      inm = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
      if (inm) r[63-p] = v.src[63 - ((p + n) % 64)];
      else     r[63-p] = (sel == 3) ? v.aux[63-p] : 1'b0;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    insn_i = v.insn; src_i = v.src; aux_i = v.aux; sh_i = v.sh; mb_i = v.mb;
    @(negedge clk);
  endtask

  task automatic full_check(input string tag, input vec_t v);
    apply(v);
    chk({tag, " result"}, result_o, ref_res(v));
    chk({tag, " valid"}, 64'(valid_o), 64'(ref_legal(v.insn)));
    chk({tag, " illegal"}, 64'(illegal_o), 64'(!ref_legal(v.insn)));
    chk({tag, " rc"}, 64'(rc_o), 64'(ref_legal(v.insn) & v.insn[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    logic [63:0] base;
    @(negedge clk);
    // initial state: all-zero inputs, field 000 legal, zero result (R8)
    chk("R8 init result", result_o, 64'h0);
    chk("R8 init valid", 64'(valid_o), 64'h1);

    for (int i = 0; i < NV; i++) full_check($sformatf("R2-6 vec%0d", i), VECS[i]);

    // R7: each illegal field, with record bit set
    for (int s = 5; s < 8; s++) begin
      v = '{32'h0000_0001 | (32'(s) << 2), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 6'd3, 6'd3};
      full_check($sformatf("R7 field%0d", s), v);
    end

    // R9: register form ignores sh and upper aux bits
    v = '{32'h0000_0010, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0009, 6'd0, 6'd12};
    apply(v); base = result_o;
    chk("R9 reg base", base, ref_res(v));
    v.sh = 6'd45; v.aux = 64'hABCD_EF00_1234_5609;
    apply(v); chk("R9 reg ignores sh/aux high", result_o, base);

    // R9: immediate clear form ignores aux
    v = '{32'h0000_0008, 64'hCAFE_BABE_1234_5678, 64'h0, 6'd12, 6'd3};
    apply(v); base = result_o;
    v.aux = 64'hFFFF_FFFF_FFFF_FFFF;
    apply(v); chk("R9 imm ignores aux", result_o, base);

    // R1: upper instruction bits have no effect
    v = '{32'h0000_000C, 64'h1357_9BDF_2468_ACE0, 64'h0F0F_F0F0_0F0F_F0F0, 6'd9, 6'd30};
    apply(v); base = result_o;
    v.insn = 32'hFFFF_FFEC;
    apply(v); chk("R1 upper insn bits", result_o, base);
    chk("R1 upper insn rc", 64'(rc_o), 64'h0);

    // R4 corner: full mask when mb=0, sh=0
    full_check("R4 full mask", '{32'h0000_0008, 64'h0123_4567_89AB_CDEF, 64'h0, 6'd0, 6'd0});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule